// File: doc/BRIEF.md
# Dual-Precision Pipelined Floating-Point Multiplier

This block multiplies two IEEE binary floating-point numbers in either single or double precision. The format is picked per operation by a precision bit at issue time. Single-precision operands and results use the low 32 bits of the 64-bit buses.

The significand datapath has one unsigned multiplier array that is 53 by 27 bits, about half the size a full double-precision product needs. A single-precision product (24 by 24 bits) fits through the array in one pass. A double-precision product goes through it twice: first with the low 27-bit slice of the second significand, then with the high 26-bit slice, and the two partial products are added. Because of this, the issue rate and the latency depend on precision.

Both formats share one round-to-nearest-even stage. That stage injects half a unit in the last place at the format's rounding position, then truncates the sum. Subnormal values are flushed to zero, and the only rounding mode is round to nearest even.

Top module: `fpm_dual_mul`

## Requirements
- R1: A single-precision operation accepted in cycle k (in_valid and in_ready high at the rising edge that ends cycle k) has out_valid high in cycle k+2. Another operation of either precision may be accepted in cycle k+1.
- R2: A double-precision operation accepted in cycle k drives in_ready low in cycle k+1 only, and has out_valid high in cycle k+3.
- R3: An in_valid presented while in_ready is low is dropped. It produces no result and does not disturb the operation in flight.
- R4: Single-precision operations issued on consecutive cycles produce results on consecutive cycles.
- R5: Results are rounded to nearest with ties to even. A result exactly halfway between two representable values takes the one whose significand LSB (result bit 0) is 0. This holds for both precisions.
- R6: The biased result exponent is the sum of the operand exponents minus the bias (127 single, 1023 double). One is added when the significand product is 2.0 or more, and one more when rounding carries the significand up to 2.0.
- R7: If the result exponent reaches 255 (single) or 2047 (double), the result is infinity with the sign of the exact product. An operand whose exponent field is all ones, multiplied by a nonzero operand, also gives signed infinity.
- R8: If the result exponent is 0 or below, the result is a zero with the product's sign.
- R9: The result sign is the XOR of the operand sign bits (bit 31 single, bit 63 double). An operand whose exponent field is zero gives a signed zero. Zero times an all-ones-exponent operand gives the quiet NaN 0x7FC00000 (single) or 0x7FF8000000000000 (double).
- R10: In single precision, operand bits 63:32 are ignored and result bits 63:32 are zero.
- R11: out_valid pulses exactly once per accepted operation, and results leave in issue order. A mixed sequence of precisions is accepted.
- R12: A synchronous reset holds out_valid low, empties the pipeline so that no result emerges from an operation issued before reset, and leaves in_ready high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation presented this cycle |
| in_dp | input | 1 | 1 = double precision, 0 = single precision |
| in_a | input | 64 | First operand (single in bits 31:0) |
| in_b | input | 64 | Second operand (single in bits 31:0) |
| in_ready | output | 1 | Low while the second double-precision pass runs |
| out_valid | output | 1 | Result valid pulse |
| out_result | output | 64 | Rounded product (single in bits 31:0) |

## Verification
On every cycle, the assertions check the precision-dependent latencies, the single stall cycle after a double-precision issue, the recovery of in_ready one cycle later, and the bubble on out_valid that follows each stall. The bench scenarios are needed for the numeric properties: ties to even in each format, the rounding carry into the exponent, saturation to infinity, flush to zero, and the special-operand results. They are also needed to show that an issue attempted during the stall leaves no trace, and that mixed-precision streams come out in order.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  localparam int SP_EXP_W  = 8;
  localparam int SP_MAN_W  = 23;
  localparam int DP_EXP_W  = 11;
  localparam int DP_MAN_W  = 52;
  localparam int SP_BIAS   = (1 << (SP_EXP_W - 1)) - 1;
  localparam int DP_BIAS   = (1 << (DP_EXP_W - 1)) - 1;
  localparam int SP_SIG_W  = SP_MAN_W + 1;
  localparam int SIG_W     = DP_MAN_W + 1;
  localparam int SLICE_W   = (SIG_W + 1) / 2;
  localparam int HI_W      = SIG_W - SLICE_W;
  localparam int PP_W      = SIG_W + SLICE_W;
  localparam int PROD_W    = 2 * SIG_W;
  localparam int SP_PROD_W = 2 * SP_SIG_W;
  localparam int EXP_W     = DP_EXP_W + 2;
  localparam int DP_LSB    = PROD_W - SIG_W;
  localparam int SP_LSB    = PROD_W - SP_SIG_W;

  typedef struct packed {
    logic                    sign;
    logic signed [EXP_W-1:0] exp_sum;
    logic                    is_zero;
    logic                    is_inf;
    logic                    is_nan;
    logic [SIG_W-1:0]        sig_a;
    logic [SIG_W-1:0]        sig_b;
  } op_info_t;
endpackage

// File: rtl/fpm_unpack.sv
module fpm_unpack
  import fpm_pkg::*;
(
  input  logic        dp,
  input  logic [63:0] a,
  input  logic [63:0] b,
  output op_info_t    info
);
  logic [DP_EXP_W-1:0] ea, eb, emax;
  logic signed [EXP_W-1:0] bias;
  logic a_zero, b_zero, a_max, b_max;

  always_comb begin
    if (dp) begin
      ea         = a[62:52];
      eb         = b[62:52];
      emax       = '1;
      bias       = EXP_W'(DP_BIAS);
      info.sign  = a[63] ^ b[63];
      info.sig_a = {1'b1, a[51:0]};
      info.sig_b = {1'b1, b[51:0]};
    end else begin
      ea         = {3'b000, a[30:23]};
      eb         = {3'b000, b[30:23]};
      emax       = DP_EXP_W'((1 << SP_EXP_W) - 1);
      bias       = EXP_W'(SP_BIAS);
      info.sign  = a[31] ^ b[31];
      info.sig_a = {{(SIG_W-SP_SIG_W){1'b0}}, 1'b1, a[22:0]};
      info.sig_b = {{(SIG_W-SP_SIG_W){1'b0}}, 1'b1, b[22:0]};
    end
    a_zero       = (ea == '0);
    b_zero       = (eb == '0);
    a_max        = (ea == emax);
    b_max        = (eb == emax);
    info.exp_sum = $signed({2'b00, ea}) + $signed({2'b00, eb}) - bias;
    info.is_zero = a_zero | b_zero;
    info.is_inf  = a_max | b_max;
    info.is_nan  = (a_zero & b_max) | (a_max & b_zero);
  end
endmodule

// File: rtl/fpm_array.sv
module fpm_array #(
  parameter int A_W = 53,
  parameter int B_W = 27
) (
  input  logic [A_W-1:0]     a,
  input  logic [B_W-1:0]     b,
  output logic [A_W+B_W-1:0] p
);
  always_comb p = (A_W+B_W)'(a) * (A_W+B_W)'(b);
endmodule

// File: rtl/fpm_round.sv
module fpm_round
  import fpm_pkg::*;
(
  input  logic                    dp,
  input  logic                    sign,
  input  logic signed [EXP_W-1:0] exp_sum,
  input  logic                    is_zero,
  input  logic                    is_inf,
  input  logic                    is_nan,
  input  logic [PROD_W-1:0]       prod,
  output logic [63:0]             result
);
  logic                    norm_hi, carry, tie;
  logic [PROD_W-1:0]       norm, inject;
  logic [PROD_W:0]         sum;
  logic signed [EXP_W-1:0] exp_r, exp_top;
  logic [DP_MAN_W-1:0]     man_dp;
  logic [SP_MAN_W-1:0]     man_sp;
  logic                    unused_sum_bits;

  always_comb begin
    norm_hi = prod[PROD_W-1];
    norm    = norm_hi ? prod : {prod[PROD_W-2:0], 1'b0};
    inject  = dp ? (PROD_W'(1) << (DP_LSB - 1)) : (PROD_W'(1) << (SP_LSB - 1));
    sum     = {1'b0, norm} + {1'b0, inject};
    carry   = sum[PROD_W];
    tie     = dp ? (norm[DP_LSB-1:0] == (DP_LSB'(1) << (DP_LSB - 1)))
                 : (norm[SP_LSB-1:0] == (SP_LSB'(1) << (SP_LSB - 1)));
    man_dp  = sum[PROD_W-2:DP_LSB];
    man_sp  = sum[PROD_W-2:SP_LSB];
    if (tie) begin
      man_dp[0] = 1'b0;
      man_sp[0] = 1'b0;
    end
    exp_r   = exp_sum + $signed({{(EXP_W-1){1'b0}}, norm_hi})
                      + $signed({{(EXP_W-1){1'b0}}, carry});
    exp_top = dp ? EXP_W'((1 << DP_EXP_W) - 1) : EXP_W'((1 << SP_EXP_W) - 1);

    if (is_nan)
      result = dp ? {1'b0, {DP_EXP_W{1'b1}}, 1'b1, {(DP_MAN_W-1){1'b0}}}
                  : {32'b0, 1'b0, {SP_EXP_W{1'b1}}, 1'b1, {(SP_MAN_W-1){1'b0}}};
    else if (is_zero || (!is_inf && exp_r <= 0))
      result = dp ? {sign, 63'b0} : {32'b0, sign, 31'b0};
    else if (is_inf || exp_r >= exp_top)
      result = dp ? {sign, {DP_EXP_W{1'b1}}, {DP_MAN_W{1'b0}}}
                  : {32'b0, sign, {SP_EXP_W{1'b1}}, {SP_MAN_W{1'b0}}};
    else
      result = dp ? {sign, exp_r[DP_EXP_W-1:0], man_dp}
                  : {32'b0, sign, exp_r[SP_EXP_W-1:0], man_sp};
  end

  assign unused_sum_bits = ^{sum[PROD_W-1], sum[DP_LSB-1:0]};
endmodule

// File: rtl/fpm_dual_mul.sv
module fpm_dual_mul
  import fpm_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic        in_dp,
  input  logic [63:0] in_a,
  input  logic [63:0] in_b,
  output logic        in_ready,
  output logic        out_valid,
  output logic [63:0] out_result
);
  op_info_t            info;
  logic                accept, pass2;
  logic [SIG_W-1:0]    arr_a;
  logic [SLICE_W-1:0]  arr_b;
  logic [PP_W-1:0]     pp;
  logic [63:0]         rounded;

  // Stage register: holds the operation between issue and rounding.
  logic                    st_valid, st_dp, st_done;
  logic                    st_sign, st_zero, st_inf, st_nan;
  logic signed [EXP_W-1:0] st_exp;
  logic [SIG_W-1:0]        st_sig_a;
  logic [HI_W-1:0]         st_b_hi;
  logic [PROD_W-1:0]       st_prod;

  fpm_unpack u_unpack (.dp(in_dp), .a(in_a), .b(in_b), .info(info));

  assign pass2    = st_valid && st_dp && !st_done;
  assign in_ready = !pass2;
  assign accept   = in_valid && in_ready;

  // One shared array: fresh operands at issue, stored high slice on pass two.
  assign arr_a = pass2 ? st_sig_a : info.sig_a;
  assign arr_b = pass2 ? {{(SLICE_W-HI_W){1'b0}}, st_b_hi} : info.sig_b[SLICE_W-1:0];

  fpm_array #(.A_W(SIG_W), .B_W(SLICE_W)) u_array (.a(arr_a), .b(arr_b), .p(pp));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_valid <= 1'b0;
      st_dp    <= 1'b0;
      st_done  <= 1'b0;
      st_sign  <= 1'b0;
      st_zero  <= 1'b0;
      st_inf   <= 1'b0;
      st_nan   <= 1'b0;
      st_exp   <= '0;
      st_sig_a <= '0;
      st_b_hi  <= '0;
      st_prod  <= '0;
    end else if (accept) begin
      st_valid <= 1'b1;
      st_dp    <= in_dp;
      st_done  <= 1'b0;
      st_sign  <= info.sign;
      st_zero  <= info.is_zero;
      st_inf   <= info.is_inf;
      st_nan   <= info.is_nan;
      st_exp   <= info.exp_sum;
      st_sig_a <= info.sig_a;
      st_b_hi  <= info.sig_b[SIG_W-1:SLICE_W];
      st_prod  <= in_dp ? {{(PROD_W-PP_W){1'b0}}, pp}
                        : {pp[SP_PROD_W-1:0], {(PROD_W-SP_PROD_W){1'b0}}};
    end else if (pass2) begin
      st_done  <= 1'b1;
      st_prod  <= st_prod + {pp[PROD_W-SLICE_W-1:0], {SLICE_W{1'b0}}};
    end else begin
      st_valid <= 1'b0;
    end
  end

  fpm_round u_round (
    .dp(st_dp), .sign(st_sign), .exp_sum(st_exp), .is_zero(st_zero),
    .is_inf(st_inf), .is_nan(st_nan), .prod(st_prod), .result(rounded)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid  <= st_valid && (!st_dp || st_done);
      out_result <= rounded;
    end
  end

  // Single precision: result two cycles after issue (R1).
  p_sp_latency_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !in_dp) |-> ##2 out_valid);
  // Double precision: result three cycles after issue (R2).
  p_dp_latency_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_dp) |-> ##3 out_valid);
  // Double-precision issue stalls the issuer for the following cycle (R2).
  p_dp_stall_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_dp) |=> !in_ready);
  // A stall never lasts longer than one cycle (R2).
  p_ready_back_r2: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> in_ready);
  // The second pass produces no result of its own (R11).
  p_stall_bubble_r11: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> !out_valid);
endmodule

// File: tb/fpm_dual_mul_tb.sv
`timescale 1ns/1ps
module fpm_dual_mul_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_dp = 1'b0;
  logic [63:0] in_a = '0, in_b = '0;
  logic in_ready, out_valid;
  logic [63:0] out_result;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  fpm_dual_mul u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_dp(in_dp),
    .in_a(in_a), .in_b(in_b), .in_ready(in_ready),
    .out_valid(out_valid), .out_result(out_result)
  );

  typedef struct packed {
    logic        dp;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] r;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 64'h00000000_3FC00000, 64'h00000000_40000000, 64'h40400000, 4'd6},
    '{1'b0, 64'hDEADBEEF_3FC00000, 64'h12345678_3FC00000, 64'h40100000, 4'd10},
    '{1'b0, 64'h00000000_C0000000, 64'h00000000_40400000, 64'hC0C00000, 4'd9},
    '{1'b0, 64'h00000000_00000000, 64'h00000000_40400000, 64'h00000000, 4'd9},
    '{1'b0, 64'h00000000_80000000, 64'h00000000_40400000, 64'h80000000, 4'd9},
    '{1'b0, 64'h00000000_7F000000, 64'h00000000_40000000, 64'h7F800000, 4'd7},
    '{1'b0, 64'h00000000_FF000000, 64'h00000000_40000000, 64'hFF800000, 4'd7},
    '{1'b0, 64'h00000000_00800000, 64'h00000000_3F000000, 64'h00000000, 4'd8},
    '{1'b0, 64'h00000000_3F800001, 64'h00000000_3FC00000, 64'h3FC00002, 4'd5},
    '{1'b0, 64'h00000000_3F800003, 64'h00000000_3FC00000, 64'h3FC00004, 4'd5},
    '{1'b0, 64'h00000000_3F800001, 64'h00000000_3F800001, 64'h3F800002, 4'd5},
    '{1'b0, 64'h00000000_3FFFFFFF, 64'h00000000_3F800001, 64'h40000000, 4'd6},
    '{1'b0, 64'h00000000_3FFFFFFF, 64'h00000000_3FFFFFFF, 64'h407FFFFE, 4'd6},
    '{1'b0, 64'h00000000_00000000, 64'h00000000_7F800000, 64'h7FC00000, 4'd9},
    '{1'b1, 64'h3FF8000000000000, 64'h4000000000000000, 64'h4008000000000000, 4'd6},
    '{1'b1, 64'hBFF8000000000000, 64'h3FF8000000000000, 64'hC002000000000000, 4'd9},
    '{1'b1, 64'h3FF0000000000001, 64'h3FF8000000000000, 64'h3FF8000000000002, 4'd5},
    '{1'b1, 64'h3FF0000000000003, 64'h3FF8000000000000, 64'h3FF8000000000004, 4'd5},
    '{1'b1, 64'h3FFFFFFFFFFFFFFF, 64'h3FF0000000000001, 64'h4000000000000000, 4'd6},
    '{1'b1, 64'h7FE0000000000000, 64'hC000000000000000, 64'hFFF0000000000000, 4'd7},
    '{1'b1, 64'h0000000000000000, 64'hC008000000000000, 64'h8000000000000000, 4'd9},
    '{1'b1, 64'h0010000000000000, 64'h3FE0000000000000, 64'h0000000000000000, 4'd8},
    '{1'b1, 64'h4008000000000000, 64'h4014000000000000, 64'h402E000000000000, 4'd6}
  };

  function automatic string tag(input logic [3:0] n);
    case (n)
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      4'd8:    return "R8";
      4'd9:    return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input logic ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Directed sequence buffers: one entry per cycle.
  logic        s_v [8];
  logic        s_dp[8];
  logic [63:0] s_a [8];
  logic [63:0] s_b [8];
  logic        e_v [8];
  logic        e_rdy[8];
  logic [63:0] e_r [8];

  task automatic clear_seq();
    for (int i = 0; i < 8; i++) begin
      s_v[i] = 0; s_dp[i] = 0; s_a[i] = '0; s_b[i] = '0;
      e_v[i] = 0; e_rdy[i] = 1; e_r[i] = '0;
    end
  endtask

  task automatic put(input int c, input int vi);
    s_v[c] = 1; s_dp[c] = VECS[vi].dp; s_a[c] = VECS[vi].a; s_b[c] = VECS[vi].b;
  endtask

  task automatic run_seq(input string req);
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); #1;
      in_valid = s_v[i]; in_dp = s_dp[i]; in_a = s_a[i]; in_b = s_b[i];
      @(negedge clk);
      check(in_ready == e_rdy[i], req, $sformatf("in_ready cycle %0d", i),
            64'(in_ready), 64'(e_rdy[i]));
      check(out_valid == e_v[i], req, $sformatf("out_valid cycle %0d", i),
            64'(out_valid), 64'(e_v[i]));
      if (e_v[i] && out_valid)
        check(out_result == e_r[i], req, $sformatf("result cycle %0d", i),
              out_result, e_r[i]);
    end
    @(posedge clk); #1; in_valid = 0;
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    // R12: reset state
    check(out_valid == 0, "R12", "out_valid after reset", 64'(out_valid), 64'd0);
    check(in_ready == 1, "R12", "in_ready after reset", 64'(in_ready), 64'd1);

    // Table walk: each vector alone, latency then value.
    for (int v = 0; v < NV; v++) begin
      @(posedge clk); #1;
      in_valid = 1; in_dp = VECS[v].dp; in_a = VECS[v].a; in_b = VECS[v].b;
      @(posedge clk); #1;
      in_valid = 0;
      lat = 1;
      forever begin
        @(negedge clk);
        if (out_valid || lat >= 6) break;
        @(posedge clk); lat++;
      end
      if (VECS[v].dp)
        check(lat == 3, "R2", "double latency", 64'(lat), 64'd3);
      else
        check(lat == 2, "R1", "single latency", 64'(lat), 64'd2);
      check(out_result == VECS[v].r, tag(VECS[v].req), $sformatf("vector %0d", v),
            out_result, VECS[v].r);
      @(posedge clk);
    end

    // R4, R11: three single-precision issues back to back.
    clear_seq();
    put(0, 0); put(1, 2); put(2, 8);
    e_v[2] = 1; e_r[2] = VECS[0].r;
    e_v[3] = 1; e_r[3] = VECS[2].r;
    e_v[4] = 1; e_r[4] = VECS[8].r;
    run_seq("R4");

    // R2, R3: issue during the stall cycle is dropped.
    clear_seq();
    put(0, 14); put(1, 0);
    e_rdy[1] = 0;
    e_v[3] = 1; e_r[3] = VECS[14].r;
    run_seq("R3");

    // R11: mixed precisions keep issue order.
    clear_seq();
    put(0, 22); put(2, 2); put(3, 16);
    e_rdy[1] = 0; e_rdy[4] = 0;
    e_v[3] = 1; e_r[3] = VECS[22].r;
    e_v[4] = 1; e_r[4] = VECS[2].r;
    e_v[6] = 1; e_r[6] = VECS[16].r;
    run_seq("R11");

    // R12: reset mid-flight discards a double-precision operation.
    @(posedge clk); #1;
    in_valid = 1; in_dp = 1; in_a = VECS[14].a; in_b = VECS[14].b;
    @(posedge clk); #1;
    in_valid = 0; rst = 1;
    @(posedge clk); #1; rst = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(out_valid == 0, "R12", "no output after reset", 64'(out_valid), 64'd0);
      check(in_ready == 1, "R12", "ready after reset", 64'(in_ready), 64'd1);
      @(posedge clk);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule